// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block reads a 16-key matrix keypad laid out as four rows by four columns. It pulls one column low at a time and watches the four row lines, which are pulled up and therefore idle high. The row lines are asynchronous, so they pass through a two-stage synchronizer before any logic uses them. When a row reads low, the active column is held in place. The press must then stay steady for a set debounce interval before the block reports it. A report is a 4-bit hexadecimal key code together with a strobe that lasts one cycle.

After a press has been reported, all four columns are pulled low, so that any key on the pad shows up on the rows. The block then waits until every row has stayed high for a full debounce interval. It ignores keys that are added while the first key is held, and it never stalls when several keys are down. Scanning restarts from column 0 once the pad is clear. The block suits a front panel or a debug keypad feeding a small controller. The code register keeps the last key until the next strobe, so a display can read it directly.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted and right after it, `col_n` is 4'b1110 (column 0 low), `key_valid` is 0 and `key_code` is 0.
- R2: While no key is down, exactly one bit of `col_n` is low. The low bit moves from column c to column (c+1) mod 4 every `SCAN_CYCLES` clock cycles (bit c of `col_n` drives column c).
- R3: The key at row r (bit r of `row_n`) and column c produces this code. Row 0 gives 1,2,3,A. Row 1 gives 4,5,6,B. Row 2 gives 7,8,9,C. Row 3 gives E,0,F,D. Within each row the codes are listed for columns 0 to 3.
- R4: A press is reported only after its row has read low for `DEBOUNCE_CYCLES` consecutive synchronized samples. A contact that bounces, or a press shorter than that, produces no strobe of its own.
- R5: Each physical press gives exactly one `key_valid` pulse, one cycle wide. `key_code` changes only together with that pulse and holds its value in between.
- R6: From the strobe onward, `col_n` is 4'b0000 until every row has read high for `DEBOUNCE_CYCLES` cycles. Keys pressed in that time, in any column, produce no strobe, including after the first key is released.
- R7: If several rows are low in the column being scanned, the lowest-numbered row is taken.
- R8: When the release interval completes, scanning resumes with `col_n` = 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_n | input | 4 | Keypad row lines, active low, asynchronous |
| col_n | output | 4 | Column drive, active low |
| key_code | output | 4 | Hex code of the last reported key |
| key_valid | output | 1 | One-cycle strobe marking a new key_code |

## Verification
The bound checker enforces the shape and rotation of the column drive, and the rule that a return to scanning always starts at column 0. It also enforces that the strobe lasts one cycle, that it occurs only while all columns are driven low, and that the code register is stable between strobes. Only the bench scenarios can show the following, because they depend on the stimulus:
- the key-to-code mapping;
- that bounce and short presses are filtered;
- that a second key held past the first key's release is never reported;
- that the lowest row wins when two keys in one column go down together.

// File: rtl/kpd_pkg.sv
// Package: shared types and tables for the keypad scanner.
// Assumes a 4x4 matrix with active-low rows and columns.
package kpd_pkg;

    localparam int NROW = 4;
    localparam int NCOL = 4;
    localparam int RW   = $clog2(NROW);
    localparam int CW   = $clog2(NCOL);

    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,   // rotating columns, looking for a low row
        ST_DEBP = 2'd1,   // column frozen, qualifying the press
        ST_HELD = 2'd2,   // press reported, waiting for an empty pad
        ST_DEBR = 2'd3    // pad empty, qualifying the release
    } kpd_state_e;

    // Maps a row/column position to its hex code (phone-style layout).
    function automatic logic [3:0] key_lookup(input logic [RW-1:0] r,
                                              input logic [CW-1:0] c);
        logic [3:0] code;
        case ({r, c})
            4'h0: code = 4'h1;  4'h1: code = 4'h2;  4'h2: code = 4'h3;  4'h3: code = 4'hA;
            4'h4: code = 4'h4;  4'h5: code = 4'h5;  4'h6: code = 4'h6;  4'h7: code = 4'hB;
            4'h8: code = 4'h7;  4'h9: code = 4'h8;  4'hA: code = 4'h9;  4'hB: code = 4'hC;
            4'hC: code = 4'hE;  4'hD: code = 4'h0;  4'hE: code = 4'hF;  default: code = 4'hD;
        endcase
        return code;
    endfunction

    // Returns the index of the lowest-numbered row that reads low.
    function automatic logic [RW-1:0] low_row(input logic [NROW-1:0] rows_n);
        logic [RW-1:0] idx;
        idx = '0;
        for (int i = NROW - 1; i >= 0; i--) begin
            if (!rows_n[i]) idx = RW'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/kpd_sync.sv
// Module: multi-stage synchronizer for asynchronous level inputs.
// Assumes the inputs are quasi-static compared with the clock. The reset
// value is all ones, which matches the idle level of pulled-up lines.
module kpd_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one register stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '1;
                else if (s == 0) chain[s] <= d_async;
                else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/kpd_timer.sv
// Module: cycle counter with synchronous clear and a terminal-count flag.
// Assumes LIMIT >= 2. done is high during the LIMIT-th cycle after a clear.
module kpd_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    // Purpose: count cycles since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/kpd_ctrl.sv
// Module: scan / debounce / hold state machine.
// Assumes rows_s is already synchronized, and that SCAN_CYCLES is at least
// the synchronizer depth plus one, so that a sample always reflects the
// column currently driven.
module kpd_ctrl
    import kpd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NROW-1:0] rows_s,
    input  logic            scan_done,
    input  logic            deb_done,
    output logic            scan_clr,
    output logic            deb_clr,
    output logic [NCOL-1:0] col_n,
    output logic [RW-1:0]   row_idx,
    output logic [CW-1:0]   col_idx,
    output logic            fire
);
    kpd_state_e    state_q, state_d;
    logic [CW-1:0] col_q, col_d;
    logic [RW-1:0] row_q, row_d;
    logic          pad_clear;

    assign pad_clear = (rows_s == '1);

    // Purpose: next-state, column and row selection.
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        row_d   = row_q;
        fire    = 1'b0;
        case (state_q)
            ST_SCAN: begin
                if (scan_done) begin
                    if (!pad_clear) begin
                        row_d   = low_row(rows_s);
                        state_d = ST_DEBP;
                    end else begin
                        col_d = col_q + 1'b1;
                    end
                end
            end
            ST_DEBP: begin
                if (rows_s[row_q])  state_d = ST_SCAN;
                else if (deb_done) begin
                    state_d = ST_HELD;
                    fire    = 1'b1;
                end
            end
            ST_HELD: begin
                if (pad_clear) state_d = ST_DEBR;
            end
            ST_DEBR: begin
                if (!pad_clear)    state_d = ST_HELD;
                else if (deb_done) begin
                    state_d = ST_SCAN;
                    col_d   = '0;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    // Purpose: state, column and row registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
        end
    end

    // Purpose: column drive; one column while searching, all of them once held.
    always_comb begin
        if (state_q == ST_SCAN || state_q == ST_DEBP) col_n = ~(NCOL'(1) << col_q);
        else                                           col_n = '0;
    end

    assign scan_clr = (state_q != ST_SCAN) || scan_done;
    assign deb_clr  = (state_q == ST_SCAN) || (state_q == ST_HELD);
    assign row_idx  = row_q;
    assign col_idx  = col_q;
endmodule

// File: rtl/kpd_encode.sv
// Module: registered key-code output with a one-cycle strobe.
// Assumes fire lasts a single cycle per press.
module kpd_encode
    import kpd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [RW-1:0] row_idx,
    input  logic [CW-1:0] col_idx,
    output logic [3:0]    key_code,
    output logic          key_valid
);
    // Purpose: capture the looked-up code and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_code  <= 4'h0;
            key_valid <= 1'b0;
        end else begin
            key_valid <= fire;
            if (fire) key_code <= key_lookup(row_idx, col_idx);
        end
    end
endmodule

// File: rtl/keypad_scanner.sv
// Module: top of the 4x4 keypad scanner.
// Assumes pulled-up rows and a keypad that shorts a row to a column while a
// key is down. SCAN_CYCLES must be at least SYNC_STAGES + 1.
module keypad_scanner #(
    parameter int SCAN_CYCLES     = 1000,
    parameter int DEBOUNCE_CYCLES = 5_000_000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] row_n,
    output logic [3:0] col_n,
    output logic [3:0] key_code,
    output logic       key_valid
);
    import kpd_pkg::*;

    logic [NROW-1:0] rows_s;
    logic            scan_done, deb_done, scan_clr, deb_clr, fire;
    logic [RW-1:0]   row_idx;
    logic [CW-1:0]   col_idx;

    kpd_sync #(.W(NROW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(row_n), .q_sync(rows_s)
    );

    kpd_timer #(.LIMIT(SCAN_CYCLES)) u_scan_tmr (
        .clk(clk), .rst_n(rst_n), .clr(scan_clr), .done(scan_done)
    );

    kpd_timer #(.LIMIT(DEBOUNCE_CYCLES)) u_deb_tmr (
        .clk(clk), .rst_n(rst_n), .clr(deb_clr), .done(deb_done)
    );

    kpd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .rows_s(rows_s),
        .scan_done(scan_done), .deb_done(deb_done),
        .scan_clr(scan_clr), .deb_clr(deb_clr),
        .col_n(col_n), .row_idx(row_idx), .col_idx(col_idx), .fire(fire)
    );

    kpd_encode u_enc (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .row_idx(row_idx), .col_idx(col_idx),
        .key_code(key_code), .key_valid(key_valid)
    );
endmodule

// File: rtl/kpd_checker.sv
// Module: port-level property checker for keypad_scanner, attached by bind.
module kpd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] col_n,
    input logic [3:0] key_code,
    input logic       key_valid
);
    // R2: either exactly one column is low, or all of them are
    p_col_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~col_n) == 1) || (col_n == 4'b0000));

    // R2: a move between single-column drives is a one-step rotation
    p_col_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~col_n) == 1 && $countones(~$past(col_n)) == 1 && col_n != $past(col_n))
        |-> col_n == {$past(col_n[2:0]), $past(col_n[3])});

    // R5: the strobe is one cycle wide
    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    // R5: the code changes only together with the strobe
    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> $stable(key_code));

    // R6: the strobe arrives when the drive switches to all columns
    p_strobe_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> col_n == 4'b0000);

    // R8: leaving the all-low drive restarts at column 0
    p_rescan_col0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_n != 4'b0000 && $past(col_n) == 4'b0000) |-> col_n == 4'b1110);
endmodule

bind keypad_scanner kpd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .col_n(col_n),
    .key_code(key_code), .key_valid(key_valid)
);

// File: tb/sim_keypad_scanner.sv
`timescale 1ns/1ps
module sim_keypad_scanner;
    localparam int SCAN = 4;
    localparam int DEB  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] row_n;
    logic [3:0] col_n;
    logic [3:0] key_code;
    logic       key_valid;

    logic [3:0][3:0] pressed = '0;   // pressed[row][col]

    int n_vec  = 0;
    int n_fail = 0;
    int strobes = 0;
    logic [3:0] exp_q[$];
    int         tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    keypad_scanner #(.SCAN_CYCLES(SCAN), .DEBOUNCE_CYCLES(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .row_n(row_n),
        .col_n(col_n), .key_code(key_code), .key_valid(key_valid)
    );

    // Keypad model: a row reads low if a pressed key sits on a driven column.
    always_comb begin
        for (int r = 0; r < 4; r++) row_n[r] = ~|(pressed[r] & ~col_n);
    end

    function automatic logic [3:0] ref_code(int r, int c);
        logic [3:0] t [16] = '{4'h1,4'h2,4'h3,4'hA, 4'h4,4'h5,4'h6,4'hB,
                               4'h7,4'h8,4'h9,4'hC, 4'hE,4'h0,4'hF,4'hD};
        return t[r*4 + c];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected code for every strobe seen.
    always @(negedge clk) begin
        if (rst_n && key_valid) begin
            strobes++;
            if (exp_q.size() == 0) begin
                n_vec++; n_fail++;
                $display("FAIL R5/R6: actual strobe code %0h expected no strobe", key_code);
            end else begin
                automatic logic [3:0] e = exp_q.pop_front();
                automatic int t = tag_q.pop_front();
                check(key_code == e, $sformatf("R%0d code", t), key_code, e);
                check(col_n == 4'b0000, "R6 drive at strobe", col_n, 0);
            end
        end
    end

    // Driver: presses one key, holds it, releases it.
    task automatic tap(input int r, input int c, input int tag);
        exp_q.push_back(ref_code(r, c));
        tag_q.push_back(tag);
        @(negedge clk) pressed[r][c] = 1'b1;
        repeat (80) @(negedge clk);
        pressed[r][c] = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        int s0;
        logic [3:0] prev;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(col_n == 4'b1110, "R1 col_n", col_n, 4'b1110);
        check(!key_valid, "R1 key_valid", key_valid, 0);
        check(key_code == 4'h0, "R1 key_code", key_code, 0);
        rst_n = 1'b1;

        // R2 rotation period and order while idle
        prev = col_n;
        while (col_n == prev) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            automatic int cyc = 0;
            prev = col_n;
            while (col_n == prev) begin @(negedge clk); cyc++; end
            check(cyc == SCAN, "R2 period", cyc, SCAN);
            check(col_n == {prev[2:0], prev[3]}, "R2 order", col_n, {prev[2:0], prev[3]});
        end

        // R3 every key maps to its code
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) tap(r, c, 3);

        // R4 bouncing contact yields one strobe
        exp_q.push_back(ref_code(2, 1)); tag_q.push_back(4);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk) pressed[2][1] = 1'b1;
            repeat (3) @(negedge clk);
            pressed[2][1] = 1'b0;
            repeat (2) @(negedge clk);
        end
        pressed[2][1] = 1'b1;
        repeat (80) @(negedge clk);
        for (int b = 0; b < 3; b++) begin   // bounce on release
            pressed[2][1] = 1'b0; repeat (3) @(negedge clk);
            pressed[2][1] = 1'b1; repeat (2) @(negedge clk);
        end
        pressed[2][1] = 1'b0;
        repeat (60) @(negedge clk);

        // R4 press shorter than the debounce interval: no strobe
        s0 = strobes;
        pressed[1][1] = 1'b1;
        repeat (DEB - 4) @(negedge clk);
        pressed[1][1] = 1'b0;
        repeat (60) @(negedge clk);
        check(strobes == s0, "R4 short press", strobes - s0, 0);

        // R6 second key in another column ignored, even after the first lifts
        s0 = strobes;
        exp_q.push_back(ref_code(0, 0)); tag_q.push_back(6);
        pressed[0][0] = 1'b1;
        repeat (80) @(negedge clk);
        pressed[2][3] = 1'b1;
        repeat (30) @(negedge clk);
        pressed[0][0] = 1'b0;
        repeat (80) @(negedge clk);
        check(strobes == s0 + 1, "R6 one strobe", strobes - s0, 1);
        check(col_n == 4'b0000, "R6 drive while held", col_n, 0);
        pressed[2][3] = 1'b0;
        repeat (DEB + 3) @(negedge clk);
        // R8 scanning resumes at column 0
        check(col_n == 4'b1110, "R8 restart", col_n, 4'b1110);
        repeat (40) @(negedge clk);
        check(strobes == s0 + 1, "R6 no late strobe", strobes - s0, 1);

        // R7 two rows in one column together: lowest row wins
        exp_q.push_back(ref_code(1, 2)); tag_q.push_back(7);
        @(negedge clk) begin pressed[1][2] = 1'b1; pressed[3][2] = 1'b1; end
        repeat (80) @(negedge clk);
        pressed = '0;
        repeat (60) @(negedge clk);

        // R5 normal operation after the above, then every press accounted for
        tap(3, 3, 5);
        check(exp_q.size() == 0, "R5 all presses strobed", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule